// File: doc/BRIEF.md
# Adjacent Key Suppression Arbiter

This block sits between raw per-key touch detection and the debounce integrator of a ten-key capacitive sensor. Every cycle it receives a candidate detection flag and a signal-change magnitude for each key. Within each suppression domain it lets through only the detection of the dominant key, so that one finger resting across closely spaced pads turns on a single key.

A two-bit mode selects how the keys are split into domains:
- Off: every key is its own domain.
- Grouped: three fixed groups that do not interact.
- Global: one domain spanning all keys.

An enable mask removes unused keys from arbitration. Keys already confirmed on by the integrator are reported back on `held`. A held key keeps its domain until it is released, so a stronger newcomer cannot take the domain from it.

The block also registers a permission flag for fast detection. It grants that permission only while suppression is off. Both outputs are registered and appear one clock after the inputs are sampled.

Top module: `aks_arbiter`

## Requirements
- R1: With mode 2'b00 (off), `pass` equals `cand & key_en`, so any combination of keys may pass together.
- R2: With mode 2'b10 (global), at most one bit of `pass` is set across all keys.
- R3: With mode 2'b01 (grouped), the domains are group 0 = keys {0,1,4,5}, group 1 = keys {2,3,6,7} and group 2 = keys {8,9}. At most one key per group passes, so up to three keys pass at once.
- R4: In grouped mode, the candidates and strengths of one group never change which key passes in another group.
- R5: When no key in a domain is held, the passing key is the enabled candidate with the largest strength in that domain. Every weaker candidate in the domain is suppressed. Key k's strength is `strength[k*8 +: 8]`, an unsigned value.
- R6: A key whose `key_en` bit is 0 never passes, and its candidate, strength and held bits do not suppress any other key.
- R7: `fast_ok` is 1 exactly when `fast_req` was 1 and the mode was off. In any suppressing mode it is 0.
- R8: When two enabled candidates in a domain tie on the largest strength, the lower-numbered key passes.
- R9: If a domain contains an enabled held key, no other key of that domain passes. The held key passes when its own `cand` bit is 1. If the domain has several enabled held keys, the lowest-numbered one owns it.
- R10: Mode 2'b11 behaves exactly as global mode.
- R11: The outputs are registered with one clock of latency. A synchronous active-high reset clears `pass` and `fast_ok` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 off, 01 grouped, 10 global, 11 global |
| fast_req | input | 1 | Request for fast detection |
| key_en | input | 10 | Per-key enable; 0 marks an unused key |
| cand | input | 10 | Raw candidate detection per key |
| held | input | 10 | Keys currently confirmed on by the integrator |
| strength | input | 80 | Signal change per key, 8 bits each, key k at [k*8 +: 8] |
| pass | output | 10 | Filtered detections forwarded to the integrator |
| fast_ok | output | 1 | Fast detection permitted |

## Verification
The assertions assume that every input is settled and stable across each rising edge. They compare the registered outputs against the inputs of the previous cycle, using `$past` of mode, enable, candidate and held. The stimulus therefore changes inputs only on the falling edge. It covers every mode, including the alternate global code. Strengths are drawn from a narrow range so that ties occur often. Held bits are applied both to enabled and to disabled keys, so the ownership rule and the exclusion of unused keys are exercised together.

// File: rtl/aks_pkg.sv
package aks_pkg;

  typedef enum logic [1:0] {
    AKS_OFF     = 2'b00,
    AKS_GROUP   = 2'b01,
    AKS_GLOBAL  = 2'b10,
    AKS_GLOBAL2 = 2'b11
  } aks_mode_e;

  localparam int unsigned NGROUPS = 3;

  // fixed grouping: pairs alternate between group 0 and 1, keys 8 and up form group 2
  function automatic int unsigned key_group(input int unsigned k);
    if (k >= 8) return 2;
    return (k >> 1) & 1;
  endfunction

  function automatic logic [63:0] group_mask(input int unsigned g);
    logic [63:0] m;
    m = '0;
    for (int unsigned k = 0; k < 64; k++) begin
      if (key_group(k) == g) m[k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/aks_pick.sv
module aks_pick #(
  parameter int unsigned N  = 10,
  parameter int unsigned SW = 8
) (
  input  logic [N-1:0]    member,
  input  logic [N-1:0]    key_en,
  input  logic [N-1:0]    cand,
  input  logic [N-1:0]    held,
  input  logic [N*SW-1:0] strength,
  output logic [N-1:0]    grant
);

  logic [N-1:0]  live;
  logic [N-1:0]  owner;
  logic          owned;
  logic [N-1:0]  best_hot;
  logic [SW-1:0] best_val;
  logic          found;

  assign live = member & key_en;

  // lowest-numbered enabled held key owns the domain
  always_comb begin
    owner = '0;
    owned = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (live[i] && held[i] && !owned) begin
        owner[i] = 1'b1;
        owned    = 1'b1;
      end
    end
  end

  // strongest candidate; strict compare keeps the lower index on a tie
  always_comb begin
    best_hot = '0;
    best_val = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (live[i] && cand[i] &&
          (!found || strength[i*SW +: SW] > best_val)) begin
        best_hot    = '0;
        best_hot[i] = 1'b1;
        best_val    = strength[i*SW +: SW];
        found       = 1'b1;
      end
    end
  end

  assign grant = owned ? (owner & cand) : best_hot;

endmodule

// File: rtl/aks_arbiter.sv
module aks_arbiter #(
  parameter int unsigned NKEYS = 10,
  parameter int unsigned SW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic                fast_req,
  input  logic [NKEYS-1:0]    key_en,
  input  logic [NKEYS-1:0]    cand,
  input  logic [NKEYS-1:0]    held,
  input  logic [NKEYS*SW-1:0] strength,
  output logic [NKEYS-1:0]    pass,
  output logic                fast_ok
);
  import aks_pkg::*;

  localparam int unsigned NDOM = NGROUPS + 1; // last domain spans every key

  logic [NKEYS-1:0] dom_grant [NDOM];
  logic [NKEYS-1:0] grouped_v;
  logic [NKEYS-1:0] pass_d;
  logic [NKEYS-1:0] pass_q;
  logic             fast_q;

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    localparam logic [NKEYS-1:0] MEMBER =
      (d < NGROUPS) ? NKEYS'(group_mask(d)) : {NKEYS{1'b1}};
    aks_pick #(.N(NKEYS), .SW(SW)) u_pick (
      .member   (MEMBER),
      .key_en   (key_en),
      .cand     (cand),
      .held     (held),
      .strength (strength),
      .grant    (dom_grant[d])
    );
  end

  always_comb begin
    grouped_v = '0;
    for (int d = 0; d < NGROUPS; d++) grouped_v = grouped_v | dom_grant[d];
  end

  always_comb begin
    unique case (aks_mode_e'(mode))
      AKS_OFF:   pass_d = cand & key_en;
      AKS_GROUP: pass_d = grouped_v;
      default:   pass_d = dom_grant[NGROUPS];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= '0;
      fast_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      fast_q <= fast_req && (mode == AKS_OFF);
    end
  end

  assign pass    = pass_q;
  assign fast_ok = fast_q;

  AST_OFF_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (mode == AKS_OFF) |=> (pass == $past(cand & key_en))); // R1

  AST_GLOBAL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mode[1]) |=> $onehot0(pass)); // R2

  for (genvar d = 0; d < NGROUPS; d++) begin : g_chk
    localparam logic [NKEYS-1:0] GM = NKEYS'(group_mask(d));
    AST_GROUP_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (mode == AKS_GROUP) |=> $onehot0(pass & GM)); // R3
  end

  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pass & ~$past(key_en)) == '0)); // R6

  AST_PASS_NEEDS_CAND: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pass & ~$past(cand)) == '0)); // R5

  AST_FAST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (mode != AKS_OFF) |=> !fast_ok); // R7

  AST_HELD_OWNS: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && (held & key_en) != '0) |=> ((pass & ~$past(held)) == '0)); // R9

endmodule

// File: tb/sim_aks_arbiter.sv
module sim_aks_arbiter;

  localparam int N  = 10;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode;
  logic          fast_req;
  logic [N-1:0]  key_en, cand, held;
  logic [N*SW-1:0] strength;
  logic [N-1:0]  pass;
  logic          fast_ok;

  int checks   = 0;
  int failures = 0;

  logic [N-1:0] exp_pass;
  logic         exp_fast;
  string        exp_tag;
  bit           exp_valid = 0;

  always #5 clk = ~clk;

  aks_arbiter #(.NKEYS(N), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .fast_req(fast_req),
    .key_en(key_en), .cand(cand), .held(held), .strength(strength),
    .pass(pass), .fast_ok(fast_ok)
  );

  function automatic int dom_of(input int k, input logic [1:0] m);
    if (m == 2'b00) return k;
    if (m == 2'b01) begin
      if (k >= 8) return 100;
      if ((k % 4) >= 2) return 101;
      return 102;
    end
    return 200;
  endfunction

  function automatic logic [N-1:0] model(input logic [1:0] m, input logic [N-1:0] en,
                                         input logic [N-1:0] c, input logic [N-1:0] h,
                                         input logic [N*SW-1:0] s);
    logic [N-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) begin
      bit win;
      int owner;
      if (!(en[k] && c[k])) continue;
      if (m == 2'b00) begin
        r[k] = 1'b1;
        continue;
      end
      owner = -1;
      for (int j = N - 1; j >= 0; j--)
        if (en[j] && h[j] && dom_of(j, m) == dom_of(k, m)) owner = j;
      if (owner >= 0) begin
        r[k] = (owner == k);
        continue;
      end
      win = 1;
      for (int j = 0; j < N; j++) begin
        if (j == k || !(en[j] && c[j]) || dom_of(j, m) != dom_of(k, m)) continue;
        if (s[j*SW +: SW] > s[k*SW +: SW]) win = 0;
        if (s[j*SW +: SW] == s[k*SW +: SW] && j < k) win = 0;
      end
      r[k] = win;
    end
    return r;
  endfunction

  task automatic compare();
    checks++;
    if (pass !== exp_pass || fast_ok !== exp_fast) begin
      failures++;
      $display("FAIL %s pass=%h fast_ok=%b expected pass=%h fast_ok=%b",
               exp_tag, pass, fast_ok, exp_pass, exp_fast);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic fr, input logic [N-1:0] en,
                       input logic [N-1:0] c, input logic [N-1:0] h,
                       input logic [N*SW-1:0] s, input string tag);
    @(negedge clk);
    if (exp_valid) compare();
    mode = m; fast_req = fr; key_en = en; cand = c; held = h; strength = s;
    exp_pass  = model(m, en, c, h, s);
    exp_fast  = fr && (m == 2'b00);
    exp_tag   = tag;
    exp_valid = 1;
  endtask

  function automatic logic [N*SW-1:0] str_set(input int a, input int va,
                                              input int b, input int vb);
    logic [N*SW-1:0] s;
    s = '0;
    for (int k = 0; k < N; k++) s[k*SW +: SW] = 8'(10 + k);
    s[a*SW +: SW] = 8'(va);
    s[b*SW +: SW] = 8'(vb);
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; mode = 2'b00; fast_req = 1; key_en = '1; cand = '1; held = '0;
    strength = '0;
    repeat (3) @(negedge clk);
    // R11: reset clears the registered outputs
    checks++;
    if (pass !== '0 || fast_ok !== 1'b0) begin
      failures++;
      $display("FAIL R11 pass=%h fast_ok=%b expected pass=0 fast_ok=0", pass, fast_ok);
    end
    rst = 0;

    apply(2'b00, 1'b1, 10'h3FF, 10'h3FF, 10'h000, str_set(0, 1, 1, 1), "R1");
    apply(2'b00, 1'b1, 10'h3FF, 10'h3FF, 10'h000, str_set(0, 1, 1, 1), "R7");
    apply(2'b10, 1'b0, 10'h3FF, 10'h224, 10'h000, str_set(5, 90, 9, 40), "R2");
    apply(2'b10, 1'b0, 10'h3FF, 10'h224, 10'h000, str_set(2, 99, 9, 40), "R5");
    apply(2'b01, 1'b0, 10'h3FF, 10'h359, 10'h000, str_set(4, 80, 6, 70), "R3");
    apply(2'b01, 1'b0, 10'h3FF, 10'h201, 10'h000, str_set(0, 1, 9, 200), "R4");
    apply(2'b10, 1'b0, 10'h3FF, 10'h088, 10'h000, str_set(3, 50, 7, 50), "R8");
    apply(2'b10, 1'b0, 10'h3DF, 10'h024, 10'h020, str_set(5, 250, 2, 5), "R6");
    apply(2'b10, 1'b0, 10'h3FF, 10'h082, 10'h080, str_set(1, 250, 7, 3), "R9");
    apply(2'b10, 1'b0, 10'h3FF, 10'h002, 10'h080, str_set(1, 250, 7, 3), "R9");
    apply(2'b01, 1'b0, 10'h3FF, 10'h013, 10'h010, str_set(0, 200, 1, 100), "R9");
    apply(2'b11, 1'b1, 10'h3FF, 10'h300, 10'h000, str_set(8, 20, 9, 60), "R10");
    apply(2'b01, 1'b1, 10'h3FF, 10'h0FF, 10'h000, str_set(0, 7, 2, 7), "R7");

    for (int i = 0; i < 400; i++) begin
      logic [N*SW-1:0] s;
      logic [1:0] m;
      for (int k = 0; k < N; k++) s[k*SW +: SW] = 8'($urandom % 4);
      m = 2'($urandom);
      apply(m, 1'($urandom), 10'($urandom) | 10'h2A5, 10'($urandom),
            (($urandom % 3) == 0) ? 10'($urandom) & 10'($urandom) : 10'h000,
            s, (m == 2'b00) ? "R1" : (m == 2'b01) ? "R3" : "R5");
    end

    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule